// File: doc/BRIEF.md
# Front Panel and Start-Up Mode Controller

This block runs the operator panel of a three-input audio converter. It reads two debounced push buttons. The select button steps among the three digital inputs on a short press, and a long hold switches the automatic input-search mode on or off. The polarity button toggles signal inversion on a short press, and a longer hold switches the wide-lock clock tracking mode on or off. It also drives the input lamps, the invert lamp and four sample-rate lamps.

From reset the controller moves through a fixed start-up sequence. It holds a mute state for one cycle. It then waits in warm-up until the oven reports ready, and then in calibration until calibration reports done. Each of these stages has its own lamp blink pattern. On entering the run state, the controller picks the lowest-numbered active input. In search mode, an input without signal is held for a programmable dwell time, and then the selection moves to the next live input. The search and wide-lock settings are loaded at reset from non-volatile copies on the inputs `nv_search` and `nv_wide`. Any change to either setting raises a one-cycle save request so that the new values can be written back.

Top module: `fp_panel_ctrl`

## Requirements
- R1: While reset is asserted, and in the mute cycle after it: mute=1, invert=0, selected input 0, lamp_input=3'b001, lamp_rate=0 and save_req=0. The search and wide-lock settings take the values of nv_search and nv_wide.
- R2: In warm-up (before oven_ready), lamp_rate alternates between 4'b0011 (the 44.1 and 48 lamps) and 4'b0000 every BLINK_HALF_CYC cycles, and mute stays at 1.
- R3: In calibration (oven ready, before cal_done), lamp_rate alternates between 4'b1100 (the 88.2 and 96 lamps) and 4'b0000, and mute stays at 1.
- R4: On the clock edge that leaves calibration, the selected input becomes the lowest-numbered input whose in_active bit is set, or input 0 if no input is active.
- R5: In run, a select press held for fewer than SEL_LONG_CYC cycles advances the selection 0→1→2→0 on the edge after release.
- R6: In run, a select hold that reaches SEL_LONG_CYC cycles toggles search mode once, on that edge. save_req is high for exactly the next cycle, and the release causes no advance.
- R7: In run, a polarity press shorter than POL_LONG_CYC cycles toggles invert, and lamp_invert follows it.
- R8: In run, a polarity hold that reaches POL_LONG_CYC cycles toggles wide_lock once and raises save_req for one cycle, and invert is not changed.
- R9: In search mode, an inactive selected input is held for DWELL_CYC cycles. The selection then moves to the next active input in the order 0→1→2→0, or to the next input in that order if none is active.
- R10: In manual mode, an inactive selected input stays selected.
- R11: mute is 0 exactly when the block is in run and the selected input's in_active bit is 1.
- R12: In run, lamp_rate is one-hot as 4'b0001<<rate_code (codes 0..3 = 44.1, 48, 88.2, 96 kHz). With wide_lock set, it alternates between that value and 4'b0000.
- R13: Button presses before the run state change neither the selection nor the invert setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_btn | input | 1 | Debounced select button level |
| pol_btn | input | 1 | Debounced polarity button level |
| in_active | input | 3 | Signal-present flag per input |
| oven_ready | input | 1 | Oven at set temperature |
| cal_done | input | 1 | Self-calibration finished |
| rate_code | input | 2 | Detected sample-rate code |
| nv_search | input | 1 | Stored search-mode setting, loaded at reset |
| nv_wide | input | 1 | Stored wide-lock setting, loaded at reset |
| sel_input | output | 2 | Selected input index (0..2) |
| mute | output | 1 | Output mute |
| invert | output | 1 | Polarity inversion |
| wide_lock | output | 1 | Wide-lock clock tracking mode |
| lamp_rate | output | 4 | Rate lamps, bit 0 = 44.1 kHz to bit 3 = 96 kHz |
| lamp_input | output | 3 | One-hot input lamps |
| lamp_invert | output | 1 | Invert lamp |
| save_req | output | 1 | One-cycle request to store the settings |
| save_search | output | 1 | Search-mode value to store |
| save_wide | output | 1 | Wide-lock value to store |

## Verification
The assertions assume that the button inputs are already debounced levels that are synchronous to clk, and that oven_ready and cal_done do not drop once they have risen. The stimulus changes every input half a cycle away from the sampling edge. It raises oven_ready and cal_done once and never withdraws them. It holds each button for a whole number of cycles that is clearly below or clearly at the threshold under test, so that every short or long event is unambiguous.

// File: rtl/fp_pkg.sv
package fp_pkg;

  typedef enum logic [1:0] {
    PH_MUTE = 2'd0,
    PH_WARM = 2'd1,
    PH_CAL  = 2'd2,
    PH_RUN  = 2'd3
  } fp_phase_e;

  localparam logic [3:0] WARM_LAMPS = 4'b0011;
  localparam logic [3:0] CAL_LAMPS  = 4'b1100;

  // next input in ring order 0 -> 1 -> 2 -> 0
  function automatic logic [1:0] fp_advance(input logic [1:0] s);
    return (s == 2'd2) ? 2'd0 : s + 2'd1;
  endfunction

  function automatic logic fp_is_active(input logic [2:0] act, input logic [1:0] s);
    case (s)
      2'd0:    return act[0];
      2'd1:    return act[1];
      2'd2:    return act[2];
      default: return 1'b0;
    endcase
  endfunction

  // lowest numbered live input, 0 when none
  function automatic logic [1:0] fp_first_active(input logic [2:0] act);
    if (act[0]) return 2'd0;
    if (act[1]) return 2'd1;
    if (act[2]) return 2'd2;
    return 2'd0;
  endfunction

  // search step: next live input after s, or plain next when none live
  function automatic logic [1:0] fp_seek_next(input logic [1:0] s, input logic [2:0] act);
    logic [1:0] c1;
    logic [1:0] c2;
    c1 = fp_advance(s);
    c2 = fp_advance(c1);
    if (fp_is_active(act, c1)) return c1;
    if (fp_is_active(act, c2)) return c2;
    return c1;
  endfunction

  function automatic logic [3:0] fp_rate_lamp(input logic [1:0] code);
    return 4'b0001 << code;
  endfunction

  function automatic logic [2:0] fp_input_lamp(input logic [1:0] s);
    return 3'b001 << s;
  endfunction

endpackage

// File: rtl/fp_hold_timer.sv
module fp_hold_timer #(
  parameter int LONG_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn,
  output logic short_evt,
  output logic long_evt
);
  localparam int W = $clog2(LONG_CYC + 1);
  localparam logic [W-1:0] LIM    = W'(LONG_CYC);
  localparam logic [W-1:0] LIM_M1 = W'(LONG_CYC - 1);

  logic [W-1:0] held;

  // held saturates at LIM once the long event has fired
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (!btn)    held <= '0;
    else if (held != LIM) held <= held + 1'b1;
  end

  assign long_evt  = btn && (held == LIM_M1);
  assign short_evt = !btn && (held != '0) && (held != LIM);

endmodule

// File: rtl/fp_blinker.sv
module fp_blinker #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic blink
);
  localparam int W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [W-1:0] LAST = W'(HALF_CYC - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      blink <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      blink <= !blink;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/fp_phase_seq.sv
module fp_phase_seq
  import fp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      oven_ready,
  input  logic      cal_done,
  output fp_phase_e phase,
  output logic      run_entry
);
  fp_phase_e nxt;

  assign run_entry = (phase == PH_CAL) && cal_done;

  always_comb begin
    nxt = phase;
    case (phase)
      PH_MUTE: nxt = PH_WARM;
      PH_WARM: if (oven_ready) nxt = PH_CAL;
      PH_CAL:  if (cal_done)   nxt = PH_RUN;
      default: nxt = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_MUTE;
    else        phase <= nxt;
  end

endmodule

// File: rtl/fp_panel_ctrl.sv
module fp_panel_ctrl
  import fp_pkg::*;
#(
  parameter int SEL_LONG_CYC   = 125_000_000,
  parameter int POL_LONG_CYC   = 187_500_000,
  parameter int BLINK_HALF_CYC = 31_250_000,
  parameter int DWELL_CYC      = 62_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_btn,
  input  logic       pol_btn,
  input  logic [2:0] in_active,
  input  logic       oven_ready,
  input  logic       cal_done,
  input  logic [1:0] rate_code,
  input  logic       nv_search,
  input  logic       nv_wide,
  output logic [1:0] sel_input,
  output logic       mute,
  output logic       invert,
  output logic       wide_lock,
  output logic [3:0] lamp_rate,
  output logic [2:0] lamp_input,
  output logic       lamp_invert,
  output logic       save_req,
  output logic       save_search,
  output logic       save_wide
);
  localparam int DW_W = $clog2(DWELL_CYC + 1);
  localparam logic [DW_W-1:0] DW_LAST = DW_W'(DWELL_CYC - 1);

  // named internal events
  logic      sel_short, sel_long, pol_short, pol_long;
  logic      run_entry, in_run, blink;
  logic      dwell_arm, dwell_done;
  fp_phase_e phase;

  logic [DW_W-1:0] dcnt;
  logic            search_mode;

  fp_hold_timer #(.LONG_CYC(SEL_LONG_CYC)) u_sel_timer (
    .clk(clk), .rst_n(rst_n), .btn(sel_btn),
    .short_evt(sel_short), .long_evt(sel_long)
  );

  fp_hold_timer #(.LONG_CYC(POL_LONG_CYC)) u_pol_timer (
    .clk(clk), .rst_n(rst_n), .btn(pol_btn),
    .short_evt(pol_short), .long_evt(pol_long)
  );

  fp_blinker #(.HALF_CYC(BLINK_HALF_CYC)) u_blink (
    .clk(clk), .rst_n(rst_n), .blink(blink)
  );

  fp_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .oven_ready(oven_ready), .cal_done(cal_done),
    .phase(phase), .run_entry(run_entry)
  );

  assign in_run     = (phase == PH_RUN);
  assign dwell_arm  = in_run && search_mode && !fp_is_active(in_active, sel_input);
  assign dwell_done = dwell_arm && (dcnt == DW_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
    end else if (!dwell_arm || dwell_done || sel_short) begin
      dcnt <= '0;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  // input selection: run entry, then manual press, then search step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_input <= 2'd0;
    end else if (run_entry) begin
      sel_input <= fp_first_active(in_active);
    end else if (in_run && sel_short) begin
      sel_input <= fp_advance(sel_input);
    end else if (dwell_done) begin
      sel_input <= fp_seek_next(sel_input, in_active);
    end
  end

  // settings
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      search_mode <= nv_search;
      wide_lock   <= nv_wide;
      invert      <= 1'b0;
      save_req    <= 1'b0;
    end else begin
      if (in_run && sel_long)  search_mode <= !search_mode;
      if (in_run && pol_long)  wide_lock   <= !wide_lock;
      if (in_run && pol_short) invert      <= !invert;
      save_req <= in_run && (sel_long || pol_long);
    end
  end

  always_comb begin
    case (phase)
      PH_WARM: lamp_rate = blink ? WARM_LAMPS : 4'b0000;
      PH_CAL:  lamp_rate = blink ? CAL_LAMPS  : 4'b0000;
      PH_RUN:  lamp_rate = (!wide_lock || blink) ? fp_rate_lamp(rate_code) : 4'b0000;
      default: lamp_rate = 4'b0000;
    endcase
  end

  assign mute        = !(in_run && fp_is_active(in_active, sel_input));
  assign lamp_input  = fp_input_lamp(sel_input);
  assign lamp_invert = invert;
  assign save_search = search_mode;
  assign save_wide   = wide_lock;

endmodule

// File: rtl/fp_panel_chk.sv
module fp_panel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_short,
  input logic       sel_long,
  input logic       pol_short,
  input logic       pol_long,
  input logic       in_run,
  input logic       run_entry,
  input logic [1:0] sel_input,
  input logic       mute,
  input logic       invert,
  input logic       wide_lock,
  input logic       search_mode,
  input logic       save_req,
  input logic [3:0] lamp_rate
);

  // R5
  short_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_run && sel_short |=> sel_input != $past(sel_input));

  // R6
  search_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_run && sel_long |=> (search_mode != $past(search_mode)) && save_req);

  // R7
  invert_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_run && pol_short |=> invert != $past(invert));

  // R8
  wide_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_run && pol_long |=> (wide_lock != $past(wide_lock)) && $stable(invert));

  // R6
  save_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_req |-> (search_mode != $past(search_mode)) || (wide_lock != $past(wide_lock)));

  // R11
  mute_outside_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_run |-> mute);

  // R12
  run_lamp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_run |-> $onehot0(lamp_rate));

  // R13
  frozen_before_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_run && !run_entry |=> $stable(sel_input) && $stable(invert));

  // R9
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_input != 2'd3);

endmodule

bind fp_panel_ctrl fp_panel_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .sel_short(sel_short), .sel_long(sel_long),
  .pol_short(pol_short), .pol_long(pol_long),
  .in_run(in_run), .run_entry(run_entry),
  .sel_input(sel_input), .mute(mute), .invert(invert),
  .wide_lock(wide_lock), .search_mode(search_mode),
  .save_req(save_req), .lamp_rate(lamp_rate)
);

// File: tb/fp_panel_ctrl_bench.sv
module fp_panel_ctrl_bench;
  localparam int SEL_L = 8;
  localparam int POL_L = 12;
  localparam int BLK   = 3;
  localparam int DWL   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_btn = 1'b0, pol_btn = 1'b0;
  logic [2:0] in_active = 3'b000;
  logic oven_ready = 1'b0, cal_done = 1'b0;
  logic [1:0] rate_code = 2'd0;
  logic nv_search = 1'b0, nv_wide = 1'b0;
  logic [1:0] sel_input;
  logic mute, invert, wide_lock, lamp_invert, save_req, save_search, save_wide;
  logic [3:0] lamp_rate;
  logic [2:0] lamp_input;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = !clk;

  fp_panel_ctrl #(.SEL_LONG_CYC(SEL_L), .POL_LONG_CYC(POL_L),
                  .BLINK_HALF_CYC(BLK), .DWELL_CYC(DWL)) u_fp_panel_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_btn(sel_btn), .pol_btn(pol_btn),
    .in_active(in_active), .oven_ready(oven_ready), .cal_done(cal_done),
    .rate_code(rate_code), .nv_search(nv_search), .nv_wide(nv_wide),
    .sel_input(sel_input), .mute(mute), .invert(invert), .wide_lock(wide_lock),
    .lamp_rate(lamp_rate), .lamp_input(lamp_input), .lamp_invert(lamp_invert),
    .save_req(save_req), .save_search(save_search), .save_wide(save_wide)
  );

  // {in_active[2:0], rate_code[1:0], lamp_rate[3:0], mute} with selection fixed at 1
  localparam logic [9:0] VEC [6] = '{
    {3'b010, 2'd0, 4'b0001, 1'b0},
    {3'b011, 2'd1, 4'b0010, 1'b0},
    {3'b101, 2'd2, 4'b0100, 1'b1},
    {3'b000, 2'd3, 4'b1000, 1'b1},
    {3'b111, 2'd3, 4'b1000, 1'b0},
    {3'b110, 2'd0, 4'b0001, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic press_sel(input int n);
    sel_btn = 1'b1; step(n); sel_btn = 1'b0; step(1);
  endtask

  task automatic press_pol(input int n);
    pol_btn = 1'b1; step(n); pol_btn = 1'b0; step(1);
  endtask

  // watch lamp_rate for n cycles: only patterns a or b, both seen
  task automatic blink_window(input string tag, input logic [3:0] a, input logic [3:0] b);
    int bad = 0;
    bit sa = 1'b0, sb = 1'b0;
    for (int i = 0; i < 12; i++) begin
      step(1);
      if (lamp_rate == a) sa = 1'b1;
      else if (lamp_rate == b) sb = 1'b1;
      else bad++;
    end
    check({tag, " stray pattern"}, bad, 0);
    check({tag, " lit phase seen"}, int'(sa), 1);
    check({tag, " dark phase seen"}, int'(sb), 1);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          fails++;
          $display("FAIL watchdog expired");
          $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
          $finish;
        end
      end
    join_none

    // R1 reset state
    step(3);
    check("R1 mute", int'(mute), 1);
    check("R1 sel", int'(sel_input), 0);
    check("R1 invert", int'(invert), 0);
    check("R1 lamp_input", int'(lamp_input), 1);
    check("R1 lamp_rate", int'(lamp_rate), 0);
    check("R1 save_req", int'(save_req), 0);
    check("R1 nv load", int'({save_search, save_wide}), 0);
    rst_n = 1'b1;

    // R13 presses in warm-up ignored
    in_active = 3'b111;
    press_sel(3);
    press_pol(3);
    check("R13 sel", int'(sel_input), 0);
    check("R13 invert", int'(invert), 0);

    // R2 warm-up lamps
    blink_window("R2", 4'b0011, 4'b0000);
    check("R2 mute", int'(mute), 1);

    // R3 calibration lamps
    oven_ready = 1'b1;
    step(1);
    blink_window("R3", 4'b1100, 4'b0000);
    check("R3 mute", int'(mute), 1);

    // R4 run entry picks lowest active input
    in_active = 3'b110;
    cal_done = 1'b1;
    step(1);
    check("R4 first active", int'(sel_input), 1);
    check("R11 mute released", int'(mute), 0);

    // R11 R12 vector table, manual mode, selection 1
    for (int i = 0; i < 6; i++) begin
      in_active = VEC[i][9:7];
      rate_code = VEC[i][6:5];
      step(1);
      check($sformatf("R12 lamp vec%0d", i), int'(lamp_rate), int'(VEC[i][4:1]));
      check($sformatf("R11 mute vec%0d", i), int'(mute), int'(VEC[i][0]));
    end

    // R10 manual mode keeps an inactive input
    in_active = 3'b000;
    step(DWL + 3);
    check("R10 manual hold", int'(sel_input), 1);

    // R5 short presses
    in_active = 3'b111;
    sel_btn = 1'b1; step(3);
    check("R5 no advance while held", int'(sel_input), 1);
    sel_btn = 1'b0; step(1);
    check("R5 advance 1->2", int'(sel_input), 2);
    check("R5 lamp_input", int'(lamp_input), 4);
    press_sel(2);
    check("R5 wrap 2->0", int'(sel_input), 0);
    press_sel(4);
    check("R5 advance 0->1", int'(sel_input), 1);

    // R6 long select hold
    sel_btn = 1'b1; step(SEL_L - 1);
    check("R6 before threshold", int'(save_search), 0);
    step(1);
    check("R6 search toggled", int'(save_search), 1);
    check("R6 save pulse", int'(save_req), 1);
    step(1);
    check("R6 save one cycle", int'(save_req), 0);
    step(4);
    sel_btn = 1'b0; step(1);
    check("R6 release no advance", int'(sel_input), 1);

    // R9 search with dwell
    in_active = 3'b001;
    step(DWL - 1);
    check("R9 dwell hold", int'(sel_input), 1);
    step(1);
    check("R9 skip to input 0", int'(sel_input), 0);
    in_active = 3'b100;
    step(DWL);
    check("R9 skip to input 2", int'(sel_input), 2);
    in_active = 3'b000;
    step(DWL);
    check("R9 all dead cycles to 0", int'(sel_input), 0);
    step(DWL);
    check("R9 all dead cycles to 1", int'(sel_input), 1);

    // R7 polarity short press
    in_active = 3'b111;
    press_pol(2);
    check("R7 invert on", int'(invert), 1);
    check("R7 lamp", int'(lamp_invert), 1);
    check("R7 no save", int'(save_req), 0);
    press_pol(5);
    check("R7 invert off", int'(invert), 0);

    // R8 polarity long hold
    pol_btn = 1'b1; step(POL_L);
    check("R8 wide on", int'(wide_lock), 1);
    check("R8 save pulse", int'(save_req), 1);
    step(2);
    pol_btn = 1'b0; step(1);
    check("R8 invert kept", int'(invert), 0);

    // R12 wide-lock blink of the rate lamp
    rate_code = 2'd2;
    blink_window("R12 wide", 4'b0100, 4'b0000);

    // R1 R4 second power-up with stored settings and no live input
    rst_n = 1'b0;
    nv_search = 1'b1; nv_wide = 1'b1;
    in_active = 3'b000;
    step(2);
    check("R1 nv search", int'(save_search), 1);
    check("R1 nv wide", int'(save_wide), 1);
    check("R1 invert cleared", int'(invert), 0);
    rst_n = 1'b1;
    step(3);
    check("R4 none active -> 0", int'(sel_input), 0);
    check("R11 mute dead input", int'(mute), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule